// File: doc/BRIEF.md
# Reset Sequencer with Cause Register

This block is the reset controller of a small microcontroller. It gathers reset requests from the power-on detector, the low-voltage detector, the watchdog, the illegal-opcode and illegal-address traps, and the external active-low reset pin. When a request arrives, it runs a counted sequence on the reference clock. First it drives the shared reset pin low through an open-drain enable, so that other chips on the board are reset as well. It then keeps the internal core reset asserted for a further phase after it lets go of the pin.

There are two sequence lengths. The traps, the watchdog and the external pin use a short one. Power loss and brown-out use a long one, which also lets the oscillator settle. During that long pin-low phase the clocks to the core and the modules are switched off. A read-only cause register records which source started the latest sequence, using one bit per source. The power-on pulse is an asynchronous input: while it is high, the block sits at the start of the long sequence.

Top module: `rstseq_ctrl`

## Requirements
- R1: While `por_pulse` is high, `pin_drive_low` = 1, `core_rst` = 1, `mod_clk_en` = 0 and `rst_cause` = 6'b000001 (bit 0 = power-on, every other bit clear).
- R2: After `por_pulse` falls, the pin is driven low for 4096 cycles, counting the cycle in which `por_pulse` falls. `mod_clk_en` is low for exactly those cycles. `core_rst` stays high for 4096 + 64 = 4160 cycles.
- R3: A low-voltage request (`lvi_req`) starts the long sequence, with the same 4096 / 4160 / 4096 cycle counts as R2, and sets `rst_cause` to 6'b000010 (bit 1).
- R4: A watchdog, illegal-opcode or illegal-address request starts the short sequence. The pin is low for 32 cycles and `core_rst` is high for 64 cycles, and `mod_clk_en` stays high throughout. `rst_cause` becomes 6'b000100, 6'b001000 or 6'b010000 respectively (bits 2, 3, 4). The sequence starts on the clock edge that samples the request.
- R5: A low level on `pin_in` that the block is not driving passes through a two-flop synchronizer. Two edges after the synchronizer first captures the low level, it starts the short sequence and sets `rst_cause` to 6'b100000 (bit 5).
- R6: When several requests arrive in the same cycle, the winner is decided by priority: power-on, then low-voltage, watchdog, illegal opcode, illegal address, and external pin last. `rst_cause` always has exactly one bit set.
- R7: A request that arrives during an active sequence restarts it from its first cycle, with the new source's length and cause bit. A power-on pulse takes over at once, asynchronously.
- R8: The pin staying low while the block drives it, and the synchronizer lag after the block releases it, are not taken as an external reset. After a sequence ends, `core_rst` stays low and `rst_cause` keeps its value.
- R9: `core_rst` is high in every cycle in which the pin is driven, and in the cycle after the pin is released. `mod_clk_en` is only low while the pin is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_pulse | input | 1 | Power-on pulse, active high, asynchronous |
| lvi_req | input | 1 | Low-voltage reset request |
| wdog_req | input | 1 | Watchdog timeout request |
| bad_op_req | input | 1 | Illegal opcode request |
| bad_addr_req | input | 1 | Illegal address request |
| pin_in | input | 1 | Sampled level of the shared reset pin |
| pin_drive_low | output | 1 | Open-drain enable, 1 pulls the pin low |
| core_rst | output | 1 | Internal reset, active high |
| mod_clk_en | output | 1 | Core and module clock enable |
| rst_cause | output | 6 | Read-only reset cause, one-hot |

## Verification
A corrupted phase register or cycle counter shows up at the ports as a pin window or core reset window of the wrong length. It is seen at the latest when the window should end, which is 32 or 64 cycles after a short request and 4096 or 4160 cycles after a long one. A wrong priority or a wrong cause capture is visible on `rst_cause` on the first clock edge after the request. A broken self-drive mask appears a few cycles after the pin is released: `core_rst` rises again and `rst_cause` flips to the external bit.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
   localparam int NUM_SRC     = 6;
   localparam int SRC_POR     = 0;
   localparam int SRC_LVI     = 1;
   localparam int SRC_WDOG    = 2;
   localparam int SRC_BADOP   = 3;
   localparam int SRC_BADADDR = 4;
   localparam int SRC_EXT     = 5;

   typedef logic [NUM_SRC-1:0] cause_t;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_DRIVE = 2'd1,
      PH_HOLD  = 2'd2
   } phase_t;
endpackage

// File: rtl/rstseq_pin_sync.sv
module rstseq_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic por,
   input  logic pin_in,
   input  logic drive_low,
   output logic ext_low_req
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rstseq_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic [STAGES-1:0] oe_hist;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or posedge por) begin
            if (por) begin
               sync_q[0]  <= 1'b1;
               oe_hist[0] <= 1'b1;
            end else begin
               sync_q[0]  <= pin_in;
               oe_hist[0] <= drive_low;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or posedge por) begin
            if (por) begin
               sync_q[s]  <= 1'b1;
               oe_hist[s] <= 1'b1;
            end else begin
               sync_q[s]  <= sync_q[s-1];
               oe_hist[s] <= oe_hist[s-1];
            end
         end
      end
   end

   // The pin only counts as an outside reset once the block's own drive
   // has had time to leave the synchronizer.
   assign ext_low_req = !sync_q[STAGES-1] && !drive_low && !(|oe_hist);
endmodule

// File: rtl/rstseq_src_arb.sv
module rstseq_src_arb
   import rstseq_pkg::*;
(
   input  cause_t req,
   output cause_t pick,
   output logic   valid,
   output logic   long_seq
);
   // The lowest index has the highest priority, so isolate the lowest set bit.
   assign pick     = req & (~req + cause_t'(1));
   assign valid    = |req;
   assign long_seq = pick[SRC_POR] | pick[SRC_LVI];
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
   import rstseq_pkg::*;
#(
   parameter int LONG_CYC  = 4096,
   parameter int SHORT_CYC = 32,
   parameter int HOLD_CYC  = 32,
   parameter int TAIL_CYC  = 64
) (
   input  logic   clk,
   input  logic   por,
   input  logic   start,
   input  logic   start_long,
   output phase_t phase,
   output logic   long_seq,
   output logic   por_seq
);
   localparam int CNT_W = $clog2(LONG_CYC);
   localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYC - 1);
   localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYC - 1);
   localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);
   localparam logic [CNT_W-1:0] TAIL_LAST  = CNT_W'(TAIL_CYC - 1);

   if (LONG_CYC < 2) begin : g_bad_long
      $error("rstseq_fsm: LONG_CYC must be at least 2");
   end
   if (SHORT_CYC < 1 || SHORT_CYC > LONG_CYC) begin : g_bad_short
      $error("rstseq_fsm: SHORT_CYC must lie in 1..LONG_CYC");
   end
   if (HOLD_CYC < 1 || HOLD_CYC > LONG_CYC) begin : g_bad_hold
      $error("rstseq_fsm: HOLD_CYC must lie in 1..LONG_CYC");
   end
   if (TAIL_CYC < 1 || TAIL_CYC > LONG_CYC) begin : g_bad_tail
      $error("rstseq_fsm: TAIL_CYC must lie in 1..LONG_CYC");
   end

   logic [CNT_W-1:0] cnt;
   logic             drive_end;
   logic             hold_end;

   assign drive_end = (cnt == (long_seq ? LONG_LAST : SHORT_LAST));
   assign hold_end  = (cnt == (long_seq ? TAIL_LAST : HOLD_LAST));

   always_ff @(posedge clk or posedge por) begin
      if (por) begin
         phase    <= PH_DRIVE;
         cnt      <= '0;
         long_seq <= 1'b1;
         por_seq  <= 1'b1;
      end else if (start) begin
         phase    <= PH_DRIVE;
         cnt      <= '0;
         long_seq <= start_long;
         por_seq  <= 1'b0;
      end else begin
         unique case (phase)
            PH_DRIVE: begin
               if (drive_end) begin
                  phase <= PH_HOLD;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_HOLD: begin
               if (hold_end) begin
                  phase <= PH_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               phase <= PH_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/rstseq_status.sv
module rstseq_status
   import rstseq_pkg::*;
(
   input  logic   clk,
   input  logic   por,
   input  logic   load,
   input  cause_t pick,
   output cause_t cause
);
   always_ff @(posedge clk or posedge por) begin
      if (por) begin
         cause <= cause_t'(1) << SRC_POR;
      end else if (load) begin
         cause <= pick;
      end
   end
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
   import rstseq_pkg::*;
#(
   parameter int LONG_CYC    = 4096,
   parameter int SHORT_CYC   = 32,
   parameter int HOLD_CYC    = 32,
   parameter int TAIL_CYC    = 64,
   parameter int SYNC_STAGES = 2,
   parameter int GATE_ON_LVI = 1
) (
   input  logic               clk,
   input  logic               por_pulse,
   input  logic               lvi_req,
   input  logic               wdog_req,
   input  logic               bad_op_req,
   input  logic               bad_addr_req,
   input  logic               pin_in,
   output logic               pin_drive_low,
   output logic               core_rst,
   output logic               mod_clk_en,
   output logic [NUM_SRC-1:0] rst_cause
);
   phase_t phase;
   logic   long_seq;
   logic   por_seq;
   logic   gate_seq;
   logic   ext_low_req;
   cause_t req;
   cause_t pick;
   logic   start;
   logic   start_long;
   cause_t cause_q;

   rstseq_pin_sync #(
      .STAGES(SYNC_STAGES)
   ) u_pin_sync (
      .clk        (clk),
      .por        (por_pulse),
      .pin_in     (pin_in),
      .drive_low  (pin_drive_low),
      .ext_low_req(ext_low_req)
   );

   // The power-on source acts asynchronously, so its request slot stays empty.
   assign req = {ext_low_req, bad_addr_req, bad_op_req, wdog_req, lvi_req, 1'b0};

   rstseq_src_arb u_arb (
      .req     (req),
      .pick    (pick),
      .valid   (start),
      .long_seq(start_long)
   );

   rstseq_fsm #(
      .LONG_CYC (LONG_CYC),
      .SHORT_CYC(SHORT_CYC),
      .HOLD_CYC (HOLD_CYC),
      .TAIL_CYC (TAIL_CYC)
   ) u_fsm (
      .clk       (clk),
      .por       (por_pulse),
      .start     (start),
      .start_long(start_long),
      .phase     (phase),
      .long_seq  (long_seq),
      .por_seq   (por_seq)
   );

   rstseq_status u_status (
      .clk  (clk),
      .por  (por_pulse),
      .load (start),
      .pick (pick),
      .cause(cause_q)
   );

   assign gate_seq      = por_seq | ((GATE_ON_LVI != 0) & long_seq);
   assign pin_drive_low = (phase == PH_DRIVE);
   assign core_rst      = (phase != PH_IDLE);
   assign mod_clk_en    = !(pin_drive_low && gate_seq);
   assign rst_cause     = cause_q;
endmodule

// File: rtl/rstseq_ctrl_chk.sv
module rstseq_ctrl_chk (
   input logic       clk,
   input logic       por_pulse,
   input logic       lvi_req,
   input logic       wdog_req,
   input logic       pin_drive_low,
   input logic       core_rst,
   input logic       mod_clk_en,
   input logic [5:0] rst_cause
);
   AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (por_pulse)
      $countones(rst_cause) == 1); // R6

   AST_PIN_IN_RST: assert property (@(posedge clk) disable iff (por_pulse)
      pin_drive_low |-> core_rst); // R9

   AST_GATE_IN_PIN: assert property (@(posedge clk) disable iff (por_pulse)
      !mod_clk_en |-> pin_drive_low); // R9

   AST_RST_AFTER_PIN: assert property (@(posedge clk) disable iff (por_pulse)
      $fell(pin_drive_low) |-> core_rst); // R9

   AST_WDOG_START: assert property (@(posedge clk) disable iff (por_pulse)
      (wdog_req && !lvi_req) |=> (rst_cause == 6'b000100) && pin_drive_low && mod_clk_en); // R4

   AST_LVI_START: assert property (@(posedge clk) disable iff (por_pulse)
      lvi_req |=> (rst_cause == 6'b000010) && pin_drive_low && !mod_clk_en); // R3
endmodule

bind rstseq_ctrl rstseq_ctrl_chk u_chk (
   .clk          (clk),
   .por_pulse    (por_pulse),
   .lvi_req      (lvi_req),
   .wdog_req     (wdog_req),
   .pin_drive_low(pin_drive_low),
   .core_rst     (core_rst),
   .mod_clk_en   (mod_clk_en),
   .rst_cause    (rst_cause)
);

// File: tb/rstseq_ctrl_tb.sv
module rstseq_ctrl_tb;
   logic       clk = 1'b0;
   logic       por_pulse = 1'b1;
   logic       lvi_req = 1'b0;
   logic       wdog_req = 1'b0;
   logic       bad_op_req = 1'b0;
   logic       bad_addr_req = 1'b0;
   logic       ext_low = 1'b0;
   logic       pin_in;
   logic       pin_drive_low;
   logic       core_rst;
   logic       mod_clk_en;
   logic [5:0] rst_cause;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   // Open-drain wire: low if the block or the outside world pulls it.
   assign pin_in = !(pin_drive_low || ext_low);

   rstseq_ctrl u_dut (
      .clk          (clk),
      .por_pulse    (por_pulse),
      .lvi_req      (lvi_req),
      .wdog_req     (wdog_req),
      .bad_op_req   (bad_op_req),
      .bad_addr_req (bad_addr_req),
      .pin_in       (pin_in),
      .pin_drive_low(pin_drive_low),
      .core_rst     (core_rst),
      .mod_clk_en   (mod_clk_en),
      .rst_cause    (rst_cause)
   );

   // Vector fields: [9:7] source code (1 lvi, 2 watchdog, 3 bad opcode,
   // 4 bad address, 5 external pin), [6:1] expected cause, [0] long sequence.
   localparam logic [9:0] VEC [0:4] = '{
      {3'd1, 6'b000010, 1'b1},
      {3'd2, 6'b000100, 1'b0},
      {3'd3, 6'b001000, 1'b0},
      {3'd4, 6'b010000, 1'b0},
      {3'd5, 6'b100000, 1'b0}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic measure(output int np, output int nr, output int ng);
      int guard;
      guard = 0;
      np = 0;
      nr = 0;
      ng = 0;
      while (!core_rst && guard < 100) begin
         @(negedge clk);
         guard++;
      end
      while (core_rst && nr < 20000) begin
         if (pin_drive_low) np++;
         if (!mod_clk_en) ng++;
         nr++;
         @(negedge clk);
      end
   endtask

   task automatic fire(input int code);
      if (code == 5) begin
         ext_low = 1'b1;
         repeat (3) @(negedge clk);
         ext_low = 1'b0;
      end else begin
         lvi_req      = (code == 1);
         wdog_req     = (code == 2);
         bad_op_req   = (code == 3);
         bad_addr_req = (code == 4);
         @(negedge clk);
         lvi_req      = 1'b0;
         wdog_req     = 1'b0;
         bad_op_req   = 1'b0;
         bad_addr_req = 1'b0;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int np;
      int nr;
      int ng;
      int pre;

      // R1: state held during the power-on pulse
      repeat (3) @(negedge clk);
      chk("R1 pin", int'(pin_drive_low), 1);
      chk("R1 core_rst", int'(core_rst), 1);
      chk("R1 clk_en", int'(mod_clk_en), 0);
      chk("R1 cause", int'(rst_cause), 1);

      // R2: full power-on sequence
      por_pulse = 1'b0;
      measure(np, nr, ng);
      chk("R2 pin cycles", np, 4096);
      chk("R2 rst cycles", nr, 4160);
      chk("R2 gated cycles", ng, 4096);
      chk("R2 cause", int'(rst_cause), 1);
      repeat (5) @(negedge clk);

      // Vector table: R3, R4, R5 and R8 for each source
      for (int i = 0; i < 5; i++) begin
         fire(int'(VEC[i][9:7]));
         measure(np, nr, ng);
         chk($sformatf("R3/R4/R5 cause vec%0d", i), int'(rst_cause), int'(VEC[i][6:1]));
         chk($sformatf("R3/R4/R5 pin vec%0d", i), np, VEC[i][0] ? 4096 : 32);
         chk($sformatf("R3/R4/R5 rst vec%0d", i), nr, VEC[i][0] ? 4160 : 64);
         chk($sformatf("R3/R4/R5 gate vec%0d", i), ng, VEC[i][0] ? 4096 : 0);
         repeat (10) @(negedge clk);
         chk($sformatf("R8 no self retrigger vec%0d", i), int'(core_rst), 0);
         chk($sformatf("R8 cause kept vec%0d", i), int'(rst_cause), int'(VEC[i][6:1]));
      end

      // R6: watchdog beats bad opcode
      wdog_req = 1'b1;
      bad_op_req = 1'b1;
      @(negedge clk);
      wdog_req = 1'b0;
      bad_op_req = 1'b0;
      chk("R6 wdog over bad_op", int'(rst_cause), 6'b000100);
      measure(np, nr, ng);
      chk("R6 short length", nr, 64);
      repeat (5) @(negedge clk);

      // R6: low-voltage beats watchdog and external pin
      lvi_req = 1'b1;
      wdog_req = 1'b1;
      ext_low = 1'b1;
      @(negedge clk);
      lvi_req = 1'b0;
      wdog_req = 1'b0;
      ext_low = 1'b0;
      chk("R6 lvi over wdog", int'(rst_cause), 6'b000010);
      measure(np, nr, ng);
      chk("R6 long pin", np, 4096);
      repeat (5) @(negedge clk);

      // R7: restart during the drive phase
      wdog_req = 1'b1;
      @(negedge clk);
      wdog_req = 1'b0;
      pre = 0;
      repeat (9) begin
         if (pin_drive_low) pre++;
         @(negedge clk);
      end
      if (pin_drive_low) pre++;
      bad_addr_req = 1'b1;
      @(negedge clk);
      bad_addr_req = 1'b0;
      chk("R7 cause updated", int'(rst_cause), 6'b010000);
      measure(np, nr, ng);
      chk("R7 pin total", pre + np, 42);
      chk("R7 rst total", pre + nr, 74);
      repeat (5) @(negedge clk);

      // R7: power-on pulse overrides a running short sequence
      wdog_req = 1'b1;
      @(negedge clk);
      wdog_req = 1'b0;
      repeat (5) @(negedge clk);
      por_pulse = 1'b1;
      #1;
      chk("R7 por cause", int'(rst_cause), 1);
      chk("R7 por gate", int'(mod_clk_en), 0);
      repeat (2) @(negedge clk);
      por_pulse = 1'b0;
      measure(np, nr, ng);
      chk("R7 por pin", np, 4096);
      chk("R7 por rst", nr, 4160);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule